// File: doc/BRIEF.md
# Receive Link Status Monitor

This block watches a received serial video link and keeps a small set of registers that a host can read. Two lock indications, one from the deserializer and one from the descrambler, arrive asynchronously and are brought into the local clock domain through synchronizer chains. The block reports the descrambler lock as a live level. It also latches a sticky flag each time either lock changes state, in either direction. A synchronous video-reset indication sets its own sticky flag, and a per-line CRC error strobe advances a saturating error counter.

A host reaches the block through a simple port with a 2-bit address and 16-bit data. Reads are combinational from the address. Writes take effect on the clock edge. The control register has two self-clearing write-one bits: one empties the error counter and the other clears the sticky flags. A third control bit is stored and puts the block into holdover, which freezes the flags and the counter until the bit is written back to zero.

Top module: `rxv_link_monitor`

## Requirements
- R1: Status register (address 0) bit 0 follows the descrambler lock input after a two-stage synchronizer. A change driven on the input is not visible after one rising edge and is visible after the second.
- R2: Status bit 1 is a sticky flag, set on any rising or falling change of the synchronized descrambler lock.
- R3: Status bit 2 is a sticky flag, set on any rising or falling change of the synchronized deserializer lock.
- R4: Status bit 3 is a sticky flag, set on the edge after a clock in which the video-reset input is high. It stays set until it is cleared. Status bits 15:4 read as zero.
- R5: The count register (address 1) holds the CRC error count in bits 14:0. The count rises by one for every clock in which the error strobe is high. Bit 15 reads as zero.
- R6: The count saturates at 0x7FFF. Further strobes leave it there.
- R7: A write to the control register (address 2) with bit 0 set zeroes the count. With bit 1 set, the write zeroes status bits 3:1. Each clear touches only its own state. Both bits are pulses and read back as zero.
- R8: When a clear and a new event fall in the same clock, the event wins. A flag set in that clock stays set, and the count becomes one.
- R9: Control bit 2 is stored and reads back. While it is set, the sticky flags and the count do not change, whether from events or from clear writes.
- R10: After reset, the status, count and control registers all read zero.
- R11: A read of address 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock |
| rst_n | input | 1 | Active-low reset, synchronous release |
| deser_lock_i | input | 1 | Deserializer lock, asynchronous |
| descr_lock_i | input | 1 | Descrambler lock, asynchronous |
| vid_rst_i | input | 1 | Video reset indication, synchronous to clk |
| crc_err_i | input | 1 | CRC error strobe, one count per high cycle |
| host_addr_i | input | 2 | Register address |
| host_wr_i | input | 1 | Write enable |
| host_wdata_i | input | 16 | Write data |
| host_rdata_o | output | 16 | Read data for host_addr_i, combinational |

## Verification
The assertions treat the video-reset and CRC error inputs as synchronous to the monitor clock. They also assume the lock inputs start low at reset, so that the synchronizer chains do not report a spurious change. The bench meets these assumptions by driving every input on the falling edge and holding both locks low through reset. The checks for same-cycle races and for holdover freezing use the synchronous inputs, whose timing is exact. The lock inputs are changed only after the bench has waited out the synchronizer latency.

// File: rtl/rxv_mon_pkg.sv
package rxv_mon_pkg;

    localparam int unsigned REG_AW = 2;
    localparam int unsigned REG_DW = 16;

    localparam logic [REG_AW-1:0] ADR_STATUS = 2'd0;
    localparam logic [REG_AW-1:0] ADR_COUNT  = 2'd1;
    localparam logic [REG_AW-1:0] ADR_CTRL   = 2'd2;

    // control write bit positions
    localparam int unsigned CTL_CLR_CNT = 0;
    localparam int unsigned CTL_CLR_FLG = 1;
    localparam int unsigned CTL_HOLD    = 2;

    // lock vector bit positions
    localparam int unsigned LK_DESCR = 0;
    localparam int unsigned LK_DESER = 1;
    localparam int unsigned LK_N     = 2;

    typedef struct packed {
        logic vid_rst;    // status bit 3
        logic deser_tgl;  // status bit 2
        logic descr_tgl;  // status bit 1
    } sticky_t;

endpackage

// File: rtl/rxv_sync.sv
module rxv_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[LAST];
endmodule

// File: rtl/rxv_flag_unit.sv
module rxv_flag_unit
    import rxv_mon_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [LK_N-1:0] lock_i,
    input  logic            vid_rst_i,
    input  logic            clr_i,
    input  logic            hold_i,
    output sticky_t         flags_o
);
    typedef struct packed {
        logic [LK_N-1:0] prev;
        sticky_t         flags;
    } flag_state_t;

    flag_state_t st_d, st_q;
    logic [LK_N-1:0] tgl;

    always_comb begin
        st_d      = st_q;
        tgl       = lock_i ^ st_q.prev;
        st_d.prev = lock_i;
        if (!hold_i) begin
            if (clr_i)          st_d.flags           = '0;
            if (tgl[LK_DESCR])  st_d.flags.descr_tgl = 1'b1;
            if (tgl[LK_DESER])  st_d.flags.deser_tgl = 1'b1;
            if (vid_rst_i)      st_d.flags.vid_rst   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q.flags;
endmodule

// File: rtl/rxv_err_count.sv
module rxv_err_count #(
    parameter int unsigned CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             clr_i,
    input  logic             hold_i,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_d, cnt_q, base;

    always_comb begin
        base  = clr_i ? '0 : cnt_q;
        cnt_d = cnt_q;
        if (!hold_i) begin
            if (inc_i && base != CNT_MAX) cnt_d = base + 1'b1;
            else                          cnt_d = base;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/rxv_link_monitor.sv
module rxv_link_monitor
    import rxv_mon_pkg::*;
#(
    parameter int unsigned CNT_W       = 15,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              deser_lock_i,
    input  logic              descr_lock_i,
    input  logic              vid_rst_i,
    input  logic              crc_err_i,
    input  logic [REG_AW-1:0] host_addr_i,
    input  logic              host_wr_i,
    input  logic [REG_DW-1:0] host_wdata_i,
    output logic [REG_DW-1:0] host_rdata_o
);
    localparam int unsigned CTL_USED = CTL_HOLD + 1;

    typedef struct packed {
        logic hold;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              ctl_wr;
    logic              clr_cnt_w;
    logic              clr_flg_w;
    logic              hold_w;
    logic [LK_N-1:0]   lock_async;
    logic [LK_N-1:0]   lock_sync;
    sticky_t           flags_w;
    logic [CNT_W-1:0]  cnt_w;
    logic              wdata_unused;

    assign wdata_unused = ^host_wdata_i[REG_DW-1:CTL_USED];

    // host write decode: clears are single-cycle pulses
    assign ctl_wr    = host_wr_i && (host_addr_i == ADR_CTRL);
    assign clr_cnt_w = ctl_wr && host_wdata_i[CTL_CLR_CNT];
    assign clr_flg_w = ctl_wr && host_wdata_i[CTL_CLR_FLG];

    always_comb begin
        ctl_d = ctl_q;
        if (ctl_wr) ctl_d.hold = host_wdata_i[CTL_HOLD];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign hold_w = ctl_q.hold;

    assign lock_async[LK_DESCR] = descr_lock_i;
    assign lock_async[LK_DESER] = deser_lock_i;

    rxv_sync #(
        .WIDTH  (LK_N),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (lock_async),
        .sync_o  (lock_sync)
    );

    rxv_flag_unit u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .lock_i    (lock_sync),
        .vid_rst_i (vid_rst_i),
        .clr_i     (clr_flg_w),
        .hold_i    (hold_w),
        .flags_o   (flags_w)
    );

    rxv_err_count #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_i   (crc_err_i),
        .clr_i   (clr_cnt_w),
        .hold_i  (hold_w),
        .count_o (cnt_w)
    );

    always_comb begin
        host_rdata_o = '0;
        unique case (host_addr_i)
            ADR_STATUS: host_rdata_o = REG_DW'({flags_w, lock_sync[LK_DESCR]});
            ADR_COUNT:  host_rdata_o = REG_DW'(cnt_w);
            ADR_CTRL:   host_rdata_o = REG_DW'({ctl_q.hold, 2'b00});
            default:    host_rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/rxv_link_monitor_chk.sv
module rxv_link_monitor_chk #(
    parameter int unsigned CNT_W = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cnt,
    input logic [2:0]       flags,
    input logic             hold,
    input logic             clr_cnt,
    input logic             clr_flg,
    input logic             crc_err,
    input logic             vid_rst
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    assert_hold_cnt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(cnt));

    assert_hold_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(flags));

    assert_saturate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX && !clr_cnt) |=> cnt == CNT_MAX);

    assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && crc_err && !clr_cnt && cnt != CNT_MAX) |=> cnt == CNT_W'($past(cnt) + 1'b1));

    assert_event_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && vid_rst) |=> flags[2]);

    assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !clr_flg && flags[2]) |=> flags[2]);
endmodule

bind rxv_link_monitor rxv_link_monitor_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt     (cnt_w),
    .flags   (flags_w),
    .hold    (hold_w),
    .clr_cnt (clr_cnt_w),
    .clr_flg (clr_flg_w),
    .crc_err (crc_err_i),
    .vid_rst (vid_rst_i)
);

// File: tb/rxv_link_monitor_test.sv
`timescale 1ns/1ps
module rxv_link_monitor_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        deser_lock_i = 1'b0;
    logic        descr_lock_i = 1'b0;
    logic        vid_rst_i = 1'b0;
    logic        crc_err_i = 1'b0;
    logic [1:0]  host_addr_i = 2'd0;
    logic        host_wr_i = 1'b0;
    logic [15:0] host_wdata_i = 16'd0;
    logic [15:0] host_rdata_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rxv_link_monitor uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .deser_lock_i (deser_lock_i),
        .descr_lock_i (descr_lock_i),
        .vid_rst_i    (vid_rst_i),
        .crc_err_i    (crc_err_i),
        .host_addr_i  (host_addr_i),
        .host_wr_i    (host_wr_i),
        .host_wdata_i (host_wdata_i),
        .host_rdata_o (host_rdata_o)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        host_addr_i = a;
        #0.5;
        v = host_rdata_o;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        host_addr_i  = a;
        host_wdata_i = d;
        host_wr_i    = 1'b1;
        step(1);
        host_wr_i    = 1'b0;
        host_wdata_i = 16'd0;
    endtask

    task automatic pulse_crc(input int n);
        if (n > 0) begin
            crc_err_i = 1'b1;
            step(n);
            crc_err_i = 1'b0;
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        step(3);
        rst_n = 1'b1;
        step(1);

        // R10 reset state
        rd(2'd0, v); check("R10 status", v, 16'h0000);
        rd(2'd1, v); check("R10 count", v, 16'h0000);
        rd(2'd2, v); check("R10 ctrl", v, 16'h0000);
        // R11 unused address
        rd(2'd3, v); check("R11 addr3", v, 16'h0000);

        // R1 descrambler level latency
        descr_lock_i = 1'b1;
        step(1);
        rd(2'd0, v); check("R1 one edge", v & 16'h1, 16'h0000);
        step(1);
        rd(2'd0, v); check("R1 two edges", v & 16'h1, 16'h0001);
        step(2);
        // R2 rising change flagged
        rd(2'd0, v); check("R2 rise flag", v, 16'h0003);
        wr(2'd2, 16'h0002);
        rd(2'd0, v); check("R7 flag clear", v, 16'h0001);
        descr_lock_i = 1'b0;
        step(4);
        rd(2'd0, v); check("R2 fall flag", v, 16'h0002);
        wr(2'd2, 16'h0002);

        // R3 deserializer change, both directions
        deser_lock_i = 1'b1;
        step(4);
        rd(2'd0, v); check("R3 rise flag", v, 16'h0004);
        wr(2'd2, 16'h0002);
        rd(2'd0, v); check("R3 cleared", v, 16'h0000);
        deser_lock_i = 1'b0;
        step(4);
        rd(2'd0, v); check("R3 fall flag", v, 16'h0004);
        wr(2'd2, 16'h0002);

        // R4 video reset flag, upper bits zero, sticky
        vid_rst_i = 1'b1;
        step(1);
        vid_rst_i = 1'b0;
        step(3);
        rd(2'd0, v); check("R4 vid reset flag", v, 16'h0008);
        check("R4 upper bits", v >> 4, 16'h0000);

        // R5 count sweep
        for (int n = 0; n <= 40; n++) begin
            wr(2'd2, 16'h0001);
            pulse_crc(n);
            rd(2'd1, v);
            check("R5 count sweep", v, 16'(n));
        end

        // R7 independent clears, self-clearing bits
        rd(2'd0, v); check("R7 flags kept by count clear", v, 16'h0008);
        wr(2'd2, 16'h0001);
        rd(2'd1, v); check("R7 count cleared", v, 16'h0000);
        pulse_crc(5);
        wr(2'd2, 16'h0002);
        rd(2'd0, v); check("R7 flags cleared", v, 16'h0000);
        rd(2'd1, v); check("R7 count kept by flag clear", v, 16'h0005);
        rd(2'd2, v); check("R7 pulse bits read zero", v, 16'h0000);

        // R8 event and clear in the same cycle
        crc_err_i    = 1'b1;
        wr(2'd2, 16'h0001);
        crc_err_i    = 1'b0;
        rd(2'd1, v); check("R8 count clear vs strobe", v, 16'h0001);
        vid_rst_i    = 1'b1;
        wr(2'd2, 16'h0002);
        vid_rst_i    = 1'b0;
        rd(2'd0, v); check("R8 flag clear vs event", v, 16'h0008);
        wr(2'd2, 16'h0003);

        // R9 holdover
        pulse_crc(3);
        wr(2'd2, 16'h0004);
        rd(2'd2, v); check("R9 hold readback", v, 16'h0004);
        pulse_crc(5);
        rd(2'd1, v); check("R9 count frozen", v, 16'h0003);
        vid_rst_i = 1'b1;
        step(1);
        vid_rst_i = 1'b0;
        rd(2'd0, v); check("R9 flags frozen", v, 16'h0000);
        wr(2'd2, 16'h0007);
        rd(2'd1, v); check("R9 clear ignored", v, 16'h0003);
        wr(2'd2, 16'h0000);
        rd(2'd2, v); check("R9 hold released", v, 16'h0000);
        pulse_crc(1);
        rd(2'd1, v); check("R9 counting resumes", v, 16'h0004);

        // R6 saturation
        wr(2'd2, 16'h0001);
        pulse_crc(32767 + 5);
        rd(2'd1, v); check("R6 saturated", v, 16'h7FFF);
        pulse_crc(1);
        rd(2'd1, v); check("R6 stays saturated", v, 16'h7FFF);
        wr(2'd2, 16'h0001);
        rd(2'd1, v); check("R6 clear from max", v, 16'h0000);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule